// File: doc/BRIEF.md
# Packed Shift Execution Unit

This unit performs logical-left, logical-right and arithmetic-right shifts on a 64-bit packed operand. The operand is split into four 16-bit lanes, two 32-bit lanes or a single 64-bit lane, and one shift count applies to every lane. The count is either an 8-bit immediate or a full 64-bit register or memory value. A count that is too large for the lane is handled by a fixed rule for each shift type.

The operand is read from an eight-entry register file. That file is aliased with an 80-bit floating-point stack: each entry has a 64-bit significand and a 16-bit sign/exponent field, and the file also holds a tag word and a top-of-stack pointer. A legal shift writes its result back into the significand of the entry it read from. It also forces that entry's exponent field to all ones and clears the tag word and the stack pointer. A separate write port stands in for the floating-point side, so the stack can preload entries and stack state. A read port lets the surrounding logic observe any entry.

Top module: `simd_shift_unit`

## Requirements
- R1: The control field `ctl_i` selects the entry in bits 2:0 and the operation in bits 5:3. The operation codes are 3'b010 for logical right, 3'b100 for arithmetic right and 3'b110 for left. The operand is the significand of the selected entry.
- R2: An operation code outside those three, or a lane select of 2'b11, is illegal. `valid_o` and `illegal_o` then rise together, `result_o` is zero, and no entry, tag word or stack pointer changes.
- R3: Lane select 2'b00 gives four 16-bit lanes, 2'b01 gives two 32-bit lanes and 2'b10 gives one 64-bit lane. Every lane shifts by the same count, and no bit crosses a lane boundary.
- R4: For logical shifts, a count above lane width minus one makes the whole 64-bit result zero.
- R5: For arithmetic right shifts, a count above lane width minus one is treated as lane width minus one, so each lane fills with its sign bit. A count of zero returns the operand unchanged.
- R6: With `cnt_src_i`=1 the count is `cnt_i[7:0]` and the upper bits are ignored. With `cnt_src_i`=0 all 64 bits of `cnt_i` are compared against the limit.
- R7: A legal shift writes the result into the selected entry's significand and sets its exponent field to 16'hFFFF. It also clears the tag word and the stack pointer to zero.
- R8: The result and `valid_o` appear on the clock edge after the edge that samples `start_i`. `valid_o` lasts one cycle per start, and back-to-back starts see each other's writeback.
- R9: Reset clears every significand and exponent field, the tag word, the stack pointer, `valid_o`, `illegal_o` and `result_o`.
- R10: When `start_i` is low, the floating-point write port loads the addressed entry's significand and exponent, together with the tag word and the stack pointer. In a cycle with `start_i` high, that port write is dropped.
- R11: A logical shift by exactly lane width minus one keeps one bit per lane: the top bit of the lane for a right shift, the bottom bit for a left shift.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start a shift this cycle |
| ctl_i | input | 6 | Entry index [2:0], operation code [5:3] |
| lane_sel_i | input | 2 | Lane size select |
| cnt_src_i | input | 1 | 1: 8-bit immediate count, 0: 64-bit count |
| cnt_i | input | 64 | Count operand |
| fpw_en_i | input | 1 | Floating-point side write enable |
| fpw_idx_i | input | 3 | Entry to load |
| fpw_sig_i | input | 64 | Significand to load |
| fpw_exp_i | input | 16 | Sign/exponent to load |
| fpw_tag_i | input | 16 | Tag word to load |
| fpw_top_i | input | 3 | Stack pointer to load |
| rd_idx_i | input | 3 | Entry to observe |
| result_o | output | 64 | Registered shift result |
| valid_o | output | 1 | Result strobe |
| illegal_o | output | 1 | Rejected operation |
| rd_sig_o | output | 64 | Significand of the observed entry |
| rd_exp_o | output | 16 | Exponent field of the observed entry |
| tag_o | output | 16 | Tag word |
| top_o | output | 3 | Stack pointer |

## Verification
Every lane size is combined with every operation on two operands: one with mixed sign bits in each lane and one with alternating bits. Used together, they show whether vacated bits are filled with sign copies or with zeros, and whether bits leak across a lane boundary. The counts 0, width minus one, width and 255 are applied in both count forms. They separate a shift that is passed through from the zeroing of logical shifts and the clamping of arithmetic ones. A 64-bit count whose upper bits are set tells the register form, which must zero or clamp, apart from the immediate form, which must ignore those bits. Illegal codes, back-to-back starts and a floating-point write colliding with a start test the writeback rules.

// File: rtl/simd_shift_pkg.sv
package simd_shift_pkg;
  typedef enum logic [2:0] {
    OP_SRL = 3'b010,
    OP_SRA = 3'b100,
    OP_SLL = 3'b110
  } shift_op_e;

  typedef enum logic [1:0] {
    LANE_16 = 2'b00,
    LANE_32 = 2'b01,
    LANE_64 = 2'b10
  } lane_e;

  typedef struct packed {
    logic      legal;
    shift_op_e op;
    logic      zero;
    logic [5:0] amt;
  } shift_cmd_t;
endpackage

// File: rtl/shift_decode.sv
module shift_decode
  import simd_shift_pkg::*;
#(
  parameter int unsigned DATA_W = 64,
  localparam int unsigned CNT_W = $clog2(DATA_W)
) (
  input  logic [2:0]        op_i,
  input  logic [1:0]        lane_sel_i,
  input  logic              cnt_src_i,
  input  logic [DATA_W-1:0] cnt_i,
  output logic              legal_o,
  output shift_op_e         op_o,
  output logic              zero_o,
  output logic [CNT_W-1:0]  amt_o
);
  logic [DATA_W-1:0] cnt_eff;
  logic [DATA_W-1:0] lim;
  logic              over;
  logic              op_ok;
  logic              lane_ok;

  always_comb begin
    op_o  = shift_op_e'(op_i);
    op_ok = (op_i == OP_SRL) || (op_i == OP_SRA) || (op_i == OP_SLL);
    lane_ok = (lane_sel_i != 2'b11);
    legal_o = op_ok && lane_ok;
  end

  // limit = lane width - 1
  always_comb begin
    case (lane_sel_i)
      LANE_16: lim = DATA_W'((DATA_W >> 2) - 1);
      LANE_32: lim = DATA_W'((DATA_W >> 1) - 1);
      default: lim = DATA_W'(DATA_W - 1);
    endcase
  end

  assign cnt_eff = cnt_src_i ? {{(DATA_W-8){1'b0}}, cnt_i[7:0]} : cnt_i;
  assign over    = cnt_eff > lim;

  always_comb begin
    if (op_i == OP_SRA) begin
      zero_o = 1'b0;
      amt_o  = over ? lim[CNT_W-1:0] : cnt_eff[CNT_W-1:0];
    end else begin
      zero_o = over;
      amt_o  = cnt_eff[CNT_W-1:0];
    end
  end
endmodule

// File: rtl/lane_shifter.sv
module lane_shifter
  import simd_shift_pkg::*;
#(
  parameter int unsigned DATA_W = 64,
  parameter int unsigned LANE_W = 16,
  localparam int unsigned CNT_W  = $clog2(DATA_W),
  localparam int unsigned NLANES = DATA_W / LANE_W
) (
  input  logic [DATA_W-1:0] data_i,
  input  shift_op_e         op_i,
  input  logic [CNT_W-1:0]  amt_i,
  output logic [DATA_W-1:0] res_o
);
  for (genvar l = 0; l < NLANES; l++) begin : g_lane
    logic [LANE_W-1:0] v;
    logic [LANE_W-1:0] r;
    assign v = data_i[l*LANE_W +: LANE_W];
    always_comb begin
      case (op_i)
        OP_SLL:  r = v << amt_i;
        OP_SRL:  r = v >> amt_i;
        default: r = $signed(v) >>> amt_i;
      endcase
    end
    assign res_o[l*LANE_W +: LANE_W] = r;
  end
endmodule

// File: rtl/alias_regfile.sv
module alias_regfile #(
  parameter int unsigned ENTRIES = 8,
  parameter int unsigned SIG_W   = 64,
  parameter int unsigned EXP_W   = 16,
  parameter int unsigned TAG_W   = 16,
  localparam int unsigned IDX_W  = $clog2(ENTRIES)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sh_we_i,
  input  logic [IDX_W-1:0] sh_idx_i,
  input  logic [SIG_W-1:0] sh_sig_i,
  input  logic             fp_we_i,
  input  logic [IDX_W-1:0] fp_idx_i,
  input  logic [SIG_W-1:0] fp_sig_i,
  input  logic [EXP_W-1:0] fp_exp_i,
  input  logic [TAG_W-1:0] fp_tag_i,
  input  logic [IDX_W-1:0] fp_top_i,
  input  logic [IDX_W-1:0] src_idx_i,
  output logic [SIG_W-1:0] src_sig_o,
  input  logic [IDX_W-1:0] rd_idx_i,
  output logic [SIG_W-1:0] rd_sig_o,
  output logic [EXP_W-1:0] rd_exp_o,
  output logic [TAG_W-1:0] tag_o,
  output logic [IDX_W-1:0] top_o
);
  logic [SIG_W-1:0] sig_q [ENTRIES];
  logic [EXP_W-1:0] exp_q [ENTRIES];
  logic [TAG_W-1:0] tag_q;
  logic [IDX_W-1:0] top_q;

  for (genvar e = 0; e < ENTRIES; e++) begin : g_ent
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        sig_q[e] <= '0;
        exp_q[e] <= '0;
      end else if (sh_we_i && sh_idx_i == IDX_W'(e)) begin
        sig_q[e] <= sh_sig_i;
        exp_q[e] <= '1;
      end else if (fp_we_i && fp_idx_i == IDX_W'(e)) begin
        sig_q[e] <= fp_sig_i;
        exp_q[e] <= fp_exp_i;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tag_q <= '0;
      top_q <= '0;
    end else if (sh_we_i) begin
      tag_q <= '0;
      top_q <= '0;
    end else if (fp_we_i) begin
      tag_q <= fp_tag_i;
      top_q <= fp_top_i;
    end
  end

  assign src_sig_o = sig_q[src_idx_i];
  assign rd_sig_o  = sig_q[rd_idx_i];
  assign rd_exp_o  = exp_q[rd_idx_i];
  assign tag_o     = tag_q;
  assign top_o     = top_q;
endmodule

// File: rtl/simd_shift_unit.sv
module simd_shift_unit
  import simd_shift_pkg::*;
#(
  parameter int unsigned DATA_W  = 64,
  parameter int unsigned ENTRIES = 8,
  parameter int unsigned EXP_W   = 16,
  parameter int unsigned TAG_W   = 16,
  localparam int unsigned IDX_W  = $clog2(ENTRIES),
  localparam int unsigned CNT_W  = $clog2(DATA_W),
  localparam int unsigned NSIZES = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [5:0]        ctl_i,
  input  logic [1:0]        lane_sel_i,
  input  logic              cnt_src_i,
  input  logic [DATA_W-1:0] cnt_i,
  input  logic              fpw_en_i,
  input  logic [IDX_W-1:0]  fpw_idx_i,
  input  logic [DATA_W-1:0] fpw_sig_i,
  input  logic [EXP_W-1:0]  fpw_exp_i,
  input  logic [TAG_W-1:0]  fpw_tag_i,
  input  logic [IDX_W-1:0]  fpw_top_i,
  input  logic [IDX_W-1:0]  rd_idx_i,
  output logic [DATA_W-1:0] result_o,
  output logic              valid_o,
  output logic              illegal_o,
  output logic [DATA_W-1:0] rd_sig_o,
  output logic [EXP_W-1:0]  rd_exp_o,
  output logic [TAG_W-1:0]  tag_o,
  output logic [IDX_W-1:0]  top_o
);
  logic              legal;
  shift_op_e         op;
  logic              zero;
  logic [CNT_W-1:0]  amt;
  logic [DATA_W-1:0] src_sig;
  logic [DATA_W-1:0] lane_res [NSIZES];
  logic [DATA_W-1:0] shifted;
  logic [DATA_W-1:0] res_d;
  logic [IDX_W-1:0]  dst_idx;
  logic              sh_we;
  logic              fp_we;

  assign dst_idx = ctl_i[IDX_W-1:0];

  shift_decode #(.DATA_W(DATA_W)) u_dec (
    .op_i       (ctl_i[5:3]),
    .lane_sel_i (lane_sel_i),
    .cnt_src_i  (cnt_src_i),
    .cnt_i      (cnt_i),
    .legal_o    (legal),
    .op_o       (op),
    .zero_o     (zero),
    .amt_o      (amt)
  );

  for (genvar g = 0; g < NSIZES; g++) begin : g_size
    lane_shifter #(
      .DATA_W (DATA_W),
      .LANE_W (DATA_W >> (NSIZES - 1 - g))
    ) u_sh (
      .data_i (src_sig),
      .op_i   (op),
      .amt_i  (amt),
      .res_o  (lane_res[g])
    );
  end

  always_comb begin
    case (lane_sel_i)
      LANE_16: shifted = lane_res[0];
      LANE_32: shifted = lane_res[1];
      default: shifted = lane_res[2];
    endcase
    res_d = (!legal || zero) ? '0 : shifted;
  end

  assign sh_we = start_i && legal;
  assign fp_we = fpw_en_i && !start_i;  // a shift owns the file in its cycle

  alias_regfile #(
    .ENTRIES (ENTRIES),
    .SIG_W   (DATA_W),
    .EXP_W   (EXP_W),
    .TAG_W   (TAG_W)
  ) u_rf (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .sh_we_i   (sh_we),
    .sh_idx_i  (dst_idx),
    .sh_sig_i  (res_d),
    .fp_we_i   (fp_we),
    .fp_idx_i  (fpw_idx_i),
    .fp_sig_i  (fpw_sig_i),
    .fp_exp_i  (fpw_exp_i),
    .fp_tag_i  (fpw_tag_i),
    .fp_top_i  (fpw_top_i),
    .src_idx_i (dst_idx),
    .src_sig_o (src_sig),
    .rd_idx_i  (rd_idx_i),
    .rd_sig_o  (rd_sig_o),
    .rd_exp_o  (rd_exp_o),
    .tag_o     (tag_o),
    .top_o     (top_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o   <= 1'b0;
      illegal_o <= 1'b0;
      result_o  <= '0;
    end else begin
      valid_o <= start_i;
      if (start_i) begin
        illegal_o <= !legal;
        result_o  <= res_d;
      end
    end
  end
endmodule

// File: rtl/simd_shift_unit_chk.sv
module simd_shift_unit_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        start_i,
  input logic [2:0]  op_i,
  input logic [1:0]  lane_sel_i,
  input logic        cnt_src_i,
  input logic [63:0] cnt_i,
  input logic [63:0] result_o,
  input logic        valid_o,
  input logic        illegal_o,
  input logic [15:0] tag_o,
  input logic [2:0]  top_o
);
  assert_valid_follows_start_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> valid_o);

  assert_valid_single_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !start_i |=> !valid_o);

  assert_illegal_zero_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o && illegal_o |-> result_o == 64'd0);

  assert_illegal_keeps_stack_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o && illegal_o |-> tag_o == $past(tag_o) && top_o == $past(top_o));

  assert_wb_clears_stack_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o && !illegal_o |-> tag_o == 16'd0 && top_o == 3'd0);

  // R4 / R6: register-form count with upper bits set always zeroes a logical shift
  assert_reg_count_over_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i && !cnt_src_i && (op_i == 3'b110 || op_i == 3'b010) && lane_sel_i != 2'b11
      && |cnt_i[63:8] |=> result_o == 64'd0);

  // R6: immediate form, low byte beyond 16-bit lane limit, logical op
  assert_imm_count_over_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i && cnt_src_i && (op_i == 3'b110 || op_i == 3'b010) && lane_sel_i == 2'b00
      && cnt_i[7:0] > 8'd15 |=> result_o == 64'd0);
endmodule

bind simd_shift_unit simd_shift_unit_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .start_i    (start_i),
  .op_i       (ctl_i[5:3]),
  .lane_sel_i (lane_sel_i),
  .cnt_src_i  (cnt_src_i),
  .cnt_i      (cnt_i),
  .result_o   (result_o),
  .valid_o    (valid_o),
  .illegal_o  (illegal_o),
  .tag_o      (tag_o),
  .top_o      (top_o)
);

// File: tb/sim_simd_shift_unit.sv
module sim_simd_shift_unit;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start_i = 1'b0;
  logic [5:0]  ctl_i = '0;
  logic [1:0]  lane_sel_i = '0;
  logic        cnt_src_i = 1'b0;
  logic [63:0] cnt_i = '0;
  logic        fpw_en_i = 1'b0;
  logic [2:0]  fpw_idx_i = '0;
  logic [63:0] fpw_sig_i = '0;
  logic [15:0] fpw_exp_i = '0;
  logic [15:0] fpw_tag_i = '0;
  logic [2:0]  fpw_top_i = '0;
  logic [2:0]  rd_idx_i = '0;
  logic [63:0] result_o;
  logic        valid_o, illegal_o;
  logic [63:0] rd_sig_o;
  logic [15:0] rd_exp_o, tag_o;
  logic [2:0]  top_o;

  simd_shift_unit u0 (.*);

  always #2 clk_i = ~clk_i;

  int compared = 0;
  int mismatched = 0;
  logic [64:0] exp_q[$];
  string       req_q[$];

  logic [63:0] m_sig [8];
  logic [15:0] m_exp [8];
  logic [15:0] m_tag;
  logic [2:0]  m_top;

  task automatic chk(string req, logic [79:0] act, logic [79:0] expv);
    compared++;
    if (act !== expv) begin
      mismatched++;
      $display("FAIL %s: actual %h expected %h", req, act, expv);
    end
  endtask

  function automatic logic [63:0] ref_shift(logic [63:0] d, logic [2:0] op, logic [1:0] lane,
                                            logic src, logic [63:0] cnt);
    logic [63:0] r = '0;
    logic [63:0] c = src ? {56'd0, cnt[7:0]} : cnt;
    int w = 16 << lane;
    int ci;
    if (c > 64'(w - 1)) begin
      if (op == 3'b100) c = 64'(w - 1);
      else return 64'd0;
    end
    ci = int'(c);
    for (int l = 0; l < 64 / w; l++)
      for (int k = 0; k < w; k++) begin
        int b = l * w + k;
        case (op)
          3'b110:  r[b] = (k >= ci) ? d[b-ci] : 1'b0;
          3'b010:  r[b] = (k + ci < w) ? d[b+ci] : 1'b0;
          default: r[b] = (k + ci < w) ? d[b+ci] : d[l*w+w-1];
        endcase
      end
    return r;
  endfunction

  // scoreboard monitor
  always @(negedge clk_i) begin
    if (rst_ni && valid_o) begin
      if (exp_q.size() == 0) chk("R8 spurious valid", 80'(valid_o), 80'(0));
      else chk(req_q.pop_front(), 80'({illegal_o, result_o}), 80'(exp_q.pop_front()));
    end
  end

  task automatic fp_load(logic [2:0] idx, logic [63:0] s, logic [15:0] e, logic [15:0] t,
                         logic [2:0] tp);
    fpw_en_i = 1'b1; fpw_idx_i = idx; fpw_sig_i = s; fpw_exp_i = e;
    fpw_tag_i = t; fpw_top_i = tp;
    @(negedge clk_i);
    fpw_en_i = 1'b0;
    m_sig[idx] = s; m_exp[idx] = e; m_tag = t; m_top = tp;
  endtask

  task automatic do_shift(logic [2:0] idx, logic [2:0] op, logic [1:0] lane, logic src,
                          logic [63:0] cnt, string req);
    bit ok = (op == 3'b010 || op == 3'b100 || op == 3'b110) && lane != 2'b11;
    logic [63:0] r = ok ? ref_shift(m_sig[idx], op, lane, src, cnt) : 64'd0;
    exp_q.push_back({!ok, r});
    req_q.push_back(req);
    if (ok) begin
      m_sig[idx] = r; m_exp[idx] = 16'hFFFF; m_tag = '0; m_top = '0;
    end
    ctl_i = {op, idx}; lane_sel_i = lane; cnt_src_i = src; cnt_i = cnt;
    start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
  endtask

  task automatic verify_entry(logic [2:0] idx, string req);
    rd_idx_i = idx;
    #1;
    chk({req, " sig"}, 80'(rd_sig_o), 80'(m_sig[idx]));
    chk({req, " exp"}, 80'(rd_exp_o), 80'(m_exp[idx]));
    chk({req, " tag"}, 80'(tag_o), 80'(m_tag));
    chk({req, " top"}, 80'(top_o), 80'(m_top));
  endtask

  task automatic shot(logic [2:0] idx, logic [63:0] pat, logic [2:0] op, logic [1:0] lane,
                      logic src, logic [63:0] cnt, string req);
    fp_load(idx, pat, 16'h4000, 16'h5555, 3'd3);
    do_shift(idx, op, lane, src, cnt, req);
    verify_entry(idx, req);
    @(negedge clk_i);
    chk("R8 valid drop", 80'(valid_o), 80'(0));
  endtask

  initial begin
    #(4 * 200000);
    chk("watchdog", 80'(1), 80'(0));
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    logic [2:0]  ops [3] = '{3'b010, 3'b100, 3'b110};
    logic [63:0] pats [2] = '{64'h8001_7FFF_0F0F_F00F, 64'hAAAA_5555_AAAA_5555};
    for (int i = 0; i < 8; i++) begin m_sig[i] = '0; m_exp[i] = '0; end
    m_tag = '0; m_top = '0;
    repeat (3) @(negedge clk_i);
    // R9: reset state
    chk("R9 valid", 80'(valid_o), 80'(0));
    chk("R9 illegal", 80'(illegal_o), 80'(0));
    chk("R9 result", 80'(result_o), 80'(0));
    verify_entry(3'd5, "R9");
    rst_ni = 1'b1;
    @(negedge clk_i);

    // R10: floating-point side load
    fp_load(3'd1, 64'h1234_5678_9ABC_DEF0, 16'h3FFF, 16'hAAAA, 3'd5);
    verify_entry(3'd1, "R10");

    // R1 R3 R4 R5 R6 R7 R11: sweep
    for (int p = 0; p < 2; p++)
      for (int ln = 0; ln < 3; ln++)
        for (int o = 0; o < 3; o++) begin
          int w = 16 << ln;
          logic [63:0] cl [4] = '{64'd0, 64'(w - 1), 64'(w), 64'd255};
          for (int ci = 0; ci < 4; ci++)
            for (int s = 0; s < 2; s++) begin
              string rq;
              if (ci >= 2) rq = (ops[o] == 3'b100) ? "R5" : "R4";
              else if (ci == 1) rq = (ops[o] == 3'b100) ? "R5" : "R11";
              else rq = (ops[o] == 3'b100) ? "R5" : "R3";
              shot(3'(ln + 2 * o), pats[p], ops[o], 2'(ln), 1'(s), cl[ci], rq);
            end
          shot(3'd7, pats[p], ops[o], 2'(ln), 1'b0, 64'h0000_0001_0000_0002, "R6");
          shot(3'd0, pats[p], ops[o], 2'(ln), 1'b1, 64'hFFFF_FFFF_FFFF_FF03, "R6");
          shot(3'd4, pats[p], ops[o], 2'(ln), 1'b1, 64'd5, "R7");
        end

    // R1: operation codes on a known operand, 32-bit lanes by 4
    shot(3'd2, 64'hF000_0001_8000_0010, 3'b010, 2'b01, 1'b1, 64'd4, "R1");
    shot(3'd2, 64'hF000_0001_8000_0010, 3'b100, 2'b01, 1'b1, 64'd4, "R1");
    shot(3'd2, 64'hF000_0001_8000_0010, 3'b110, 2'b01, 1'b1, 64'd4, "R1");

    // R2: illegal codes and lane select
    shot(3'd3, 64'hDEAD_BEEF_0123_4567, 3'b000, 2'b00, 1'b1, 64'd1, "R2");
    shot(3'd3, 64'hDEAD_BEEF_0123_4567, 3'b111, 2'b01, 1'b1, 64'd1, "R2");
    shot(3'd3, 64'hDEAD_BEEF_0123_4567, 3'b001, 2'b10, 1'b0, 64'd2, "R2");
    shot(3'd3, 64'hDEAD_BEEF_0123_4567, 3'b110, 2'b11, 1'b1, 64'd1, "R2");

    // R8: back-to-back shifts chain through the file
    fp_load(3'd6, 64'h0001_0002_0003_0004, 16'h1111, 16'h2222, 3'd6);
    do_shift(3'd6, 3'b110, 2'b00, 1'b1, 64'd1, "R8");
    do_shift(3'd6, 3'b110, 2'b00, 1'b1, 64'd2, "R8");
    verify_entry(3'd6, "R8");
    @(negedge clk_i);

    // R10: a port write colliding with a start is dropped
    fp_load(3'd5, 64'h00FF_00FF_00FF_00FF, 16'h7777, 16'h3333, 3'd2);
    fpw_en_i = 1'b1; fpw_idx_i = 3'd5; fpw_sig_i = 64'h1;
    fpw_exp_i = 16'h0; fpw_tag_i = 16'h9999; fpw_top_i = 3'd7;
    do_shift(3'd5, 3'b010, 2'b00, 1'b1, 64'd4, "R10");
    fpw_en_i = 1'b0;
    verify_entry(3'd5, "R10");
    @(negedge clk_i);

    repeat (3) @(negedge clk_i);
    chk("R8 queue drained", 80'(exp_q.size()), 80'(0));
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule